// File: doc/BRIEF.md
# Serial Divider Programming Port

This block takes divider settings for a frequency synthesizer over a three-wire serial link: a data line, a shift clock and a load strobe. Each rising edge of the shift clock moves one data bit into a 32-bit shift register. The bit shifted in last sits in a one-bit control position at the bottom of the register.

The link inputs are asynchronous to the system clock. The shift clock, the data line and the strobe pass through two-flop synchronizers. The shift clock edge is then detected in the system clock domain.

While the strobe is high, the loop and swallow counts (N and A) are copied from the shift register on every system clock. The 14-bit reference count is copied only when the control bit is 1 and the value is a legal reference count. While the strobe is low, all three outputs hold. The top stage of the shift register drives a serial output, so several devices can be chained.

Top module: `serial_divider_loader`

## Requirements
- R1: After reset the reference output is 3, the loop (N) and swallow (A) outputs are 0, and the serial output is 0.
- R2: Each rising edge of the shift clock shifts the register up by one place and enters the data bit at bit 0. The serial output is bit 31, so a bit reappears there 31 edges after it entered.
- R3: Changes on the data line with no rising edge of the shift clock do not alter the shift register or the serial output.
- R4: Field positions, with bit 0 being the last bit shifted in: bit 0 is the control bit, bits 7..1 are A, bits 17..8 are N, and bits 14..1 are the reference value.
- R5: While the strobe is high, N and A take the register fields whatever the control bit holds.
- R6: While the strobe is high and the control bit is 1, the reference output takes bits 14..1.
- R7: A control bit of 0 leaves the reference output unchanged through a strobe.
- R8: The outputs follow the register for as long as the strobe stays high, and they hold while the strobe is low, even if shifting continues.
- R9: A reference value below 3 is never loaded; the previous reference value is kept. N and A still load.
- R10: The serial output does not depend on the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_clk | input | 1 | Shift clock; data is shifted on its rising edge (asynchronous) |
| load_en | input | 1 | Load strobe; latches are transparent while high (asynchronous) |
| ref_div | output | 14 | Latched reference divide value |
| n_div | output | 10 | Latched loop (N) divide value |
| a_div | output | 7 | Latched swallow (A) divide value |
| ser_out | output | 1 | Top stage of the shift register |

## Verification
Several frames are sent, each with a different control bit and different field contents. Frames that differ only in the control bit show whether the reference load is gated correctly while N and A always load. Distinct bit patterns in N, A and the overlapping reference bits expose misplaced or swapped fields. A frame carrying a reference of 2 shows whether illegal values are rejected.

Data toggles without shift-clock edges show whether shifts are edge-qualified. A frame shifted with the strobe held high, followed by one shifted with it low, separates transparent loading from holding. The serial output is compared with the bit pushed in 31 edges earlier, both with the strobe high and with it low.

// File: rtl/serial_divider_loader.sv
module serial_divider_loader #(
  parameter int SR_W    = 32,
  parameter int R_W     = 14,
  parameter int N_W     = 10,
  parameter int A_W     = 7,
  parameter int REF_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           load_en,
  output logic [R_W-1:0] ref_div,
  output logic [N_W-1:0] n_div,
  output logic [A_W-1:0] a_div,
  output logic           ser_out
);
  localparam int A_LO = 1;
  localparam int N_LO = A_LO + A_W;
  localparam int R_LO = 1;

  logic [2:0]      sclk_p;
  logic [1:0]      data_p;
  logic [1:0]      strb_p;
  logic [SR_W-1:0] sr;

  wire             sclk_rise = sclk_p[1] & ~sclk_p[2];
  wire             data_s    = data_p[1];
  wire             strb_s    = strb_p[1];
  wire [R_W-1:0]   ref_new   = sr[R_LO +: R_W];
  wire             ref_ok    = sr[0] && (ref_new >= R_W'(REF_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      data_p <= '0;
      strb_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], ser_clk};
      data_p <= {data_p[0], ser_data};
      strb_p <= {strb_p[0], load_en};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sr[SR_W-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div <= R_W'(REF_MIN);
      n_div   <= '0;
      a_div   <= '0;
    end else if (strb_s) begin
      n_div <= sr[N_LO +: N_W];
      a_div <= sr[A_LO +: A_W];
      if (ref_ok) ref_div <= ref_new;
    end
  end

  assign ser_out = sr[SR_W-1];

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) sclk_rise |=> sr[0] == $past(data_s)); // R2
  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sclk_rise |=> $stable(sr)); // R3
  AST_STROBE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !strb_s |=> $stable(ref_div) && $stable(n_div) && $stable(a_div)); // R8
  AST_CTRL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (strb_s && !sr[0]) |=> $stable(ref_div)); // R7
  AST_REF_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ref_div >= R_W'(REF_MIN)); // R9
  AST_NA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (strb_s && !sclk_rise) |=> n_div == sr[N_LO +: N_W] && a_div == sr[A_LO +: A_W]); // R5
endmodule

// File: tb/tb_serial_divider_loader.sv
module tb_serial_divider_loader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ser_data = 0;
  logic        ser_clk = 0;
  logic        load_en = 0;
  logic [13:0] ref_div;
  logic [9:0]  n_div;
  logic [6:0]  a_div;
  logic        ser_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  serial_divider_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_en(load_en), .ref_div(ref_div), .n_div(n_div), .a_div(a_div),
    .ser_out(ser_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(3);
    ser_clk = 1;
    wait_clk(4);
    ser_clk = 0;
    wait_clk(3);
  endtask

  task automatic send_frame(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    wait_clk(3);
  endtask

  task automatic strobe();
    load_en = 1;
    wait_clk(5);
    load_en = 0;
    wait_clk(5);
  endtask

  function automatic logic [31:0] frame(input logic [13:0] top, input logic [9:0] n,
                                        input logic [6:0] a, input logic c);
    return {top, n, a, c};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ref", ref_div, 3);
    chk("R1 n", n_div, 0);
    chk("R1 a", a_div, 0);
    chk("R1 ser_out", ser_out, 0);
  endtask

  task automatic t_ctrl_one();
    logic [31:0] w = frame(14'h2A5C, 10'h2B7, 7'h35, 1'b1);
    send_frame(w);
    @(negedge clk);
    chk("R2 ser_out first bit", ser_out, w[31]);
    strobe();
    @(negedge clk);
    chk("R5 n", n_div, w[17:8]);
    chk("R5 a", a_div, w[7:1]);
    chk("R6 R4 ref", ref_div, w[14:1]);
  endtask

  task automatic t_ctrl_zero();
    logic [13:0] old_ref = ref_div;
    logic [31:0] w = frame(14'h1111, 10'h14C, 7'h4A, 1'b0);
    send_frame(w);
    strobe();
    @(negedge clk);
    chk("R5 n ctrl0", n_div, w[17:8]);
    chk("R5 a ctrl0", a_div, w[7:1]);
    chk("R7 ref held", ref_div, old_ref);
  endtask

  task automatic t_no_edge();
    logic [31:0] w = frame(14'h0F0F, 10'h3C3, 7'h1E, 1'b1);
    send_frame(w);
    for (int i = 0; i < 8; i++) begin
      ser_data = i[0];
      wait_clk(4);
    end
    @(negedge clk);
    chk("R3 ser_out", ser_out, w[31]);
    strobe();
    @(negedge clk);
    chk("R3 n", n_div, w[17:8]);
    chk("R3 a", a_div, w[7:1]);
  endtask

  task automatic t_low_ref();
    logic [13:0] old_ref = ref_div;
    logic [31:0] w = {17'h0, 14'd2, 1'b1};
    send_frame(w);
    strobe();
    @(negedge clk);
    chk("R9 ref kept", ref_div, old_ref);
    chk("R9 n still loads", n_div, w[17:8]);
    chk("R9 a still loads", a_div, w[7:1]);
  endtask

  task automatic t_transparent();
    logic [31:0] w1 = frame(14'h3AAA, 10'h155, 7'h2A, 1'b1);
    logic [31:0] w2 = frame(14'h0555, 10'h0AA, 7'h55, 1'b1);
    load_en = 1;
    send_frame(w1);
    @(negedge clk);
    chk("R8 n follows", n_div, w1[17:8]);
    chk("R8 a follows", a_div, w1[7:1]);
    chk("R8 ref follows", ref_div, w1[14:1]);
    chk("R10 ser_out strobe high", ser_out, w1[31]);
    load_en = 0;
    wait_clk(5);
    send_frame(w2);
    @(negedge clk);
    chk("R8 n holds", n_div, w1[17:8]);
    chk("R8 a holds", a_div, w1[7:1]);
    chk("R8 ref holds", ref_div, w1[14:1]);
    chk("R10 ser_out strobe low", ser_out, w2[31]);
    send_bit(1'b0);
    @(negedge clk);
    chk("R2 ser_out after one shift", ser_out, w2[30]);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    t_reset();
    t_ctrl_one();
    t_ctrl_zero();
    t_no_edge();
    t_low_ref();
    t_transparent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1200000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule